// File: doc/BRIEF.md
# TLB Replacement Counter Register

This block is a memory-management control register that holds a software-programmable replacement boundary and a replacement counter. The counter names the unified-TLB entry that the next TLB-load instruction overwrites. Every cycle in which the TLB is accessed, the counter advances by one. When a nonzero boundary is set, the counter wraps at that boundary. A TLB-load instruction never moves the counter.

The same word carries two more controls. One is the store-queue privilege mode. The block checks it against the privilege level of a store-queue access and raises an address-error indication for a forbidden user access. The other is the single/multiple virtual-memory mode select. A write-one trigger bit issues a single-cycle invalidate pulse. A mode change written without that trigger sets a sticky protocol-error flag.

Top module: `tlb_repl_ctrl`

## Requirements
- R1: After reset, the boundary, counter, store-queue mode and virtual-memory mode are all 0. The read word, the invalidate pulse and the protocol-error flag are also 0.
- R2: The read word holds the boundary in bits 23:18, the counter in bits 15:10, the store-queue mode in bit 9 and the virtual-memory mode in bit 8. All other bits read 0, and writes to them have no effect.
- R3: In each cycle with the access strobe high, no load strobe and no register write, the counter advances by one.
- R4: When the boundary is nonzero and an increment finds the counter equal to the boundary, the counter becomes 0.
- R5: When the boundary is 0, the counter runs through all 64 values and wraps from 63 to 0.
- R6: A counter written above the boundary keeps incrementing up to 63, then wraps to 0.
- R7: While the load strobe is high, the counter does not change, even when the access strobe is also high.
- R8: A register write sets the counter to the written bits 15:10. The write takes priority over an increment in the same cycle.
- R9: `sqPrivOnly` follows bit 9. `sqAddrErr` is high in the same cycle exactly when `sqAccess` is high, `sqUser` is high and bit 9 is 1.
- R10: `singleVmMode` follows bit 8 (0 = multiple, 1 = single virtual memory).
- R11: A write with bit 2 set produces `invPulse` high for exactly the next cycle. Bit 2 always reads 0.
- R12: A write that changes bit 8 while bit 2 is 0 sets `protoErr` from the next cycle. The flag then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write word |
| regRdData | output | 32 | Register read word |
| tlbAccess | input | 1 | TLB accessed strobe |
| tlbLoad | input | 1 | TLB-load instruction strobe |
| sqAccess | input | 1 | Store-queue access present |
| sqUser | input | 1 | Store-queue access is from user level |
| replIndex | output | 6 | Current replacement entry index |
| sqPrivOnly | output | 1 | Store queues restricted to privileged level |
| singleVmMode | output | 1 | Single virtual-memory mode selected |
| sqAddrErr | output | 1 | Address error for forbidden store-queue access |
| invPulse | output | 1 | Single-cycle invalidate request |
| protoErr | output | 1 | Sticky mode-change protocol error |

## Verification
The bench sets the counter equal to the boundary, then one above it, then to 63 with a zero boundary. A design that compared with "greater or equal" would snap an above-boundary counter straight to 0. A design that wrapped at 63 incorrectly would stick or overflow. The bench also raises the load and access strobes together, and a design that ignored the load strobe would advance the index. It places a write in the same cycle as an increment to catch a design that gave the increment priority. It flips bit 8 with and without the trigger bit, and a design that set the error flag on the legal path, or let the flag fall again, shows up there.

// File: rtl/tlb_repl_pkg.sv
package tlb_repl_pkg;
  localparam int IDX_W   = 6;
  localparam int WORD_W  = 32;
  localparam int BND_LSB = 18;
  localparam int CNT_LSB = 10;
  localparam int SQ_BIT  = 9;
  localparam int SV_BIT  = 8;
  localparam int INV_BIT = 2;

  typedef struct packed {
    logic loadCfg;
    logic stepCnt;
    logic wrapCnt;
  } ctrlStrobes_t;
endpackage

// File: rtl/tlb_repl_ctrl_fsm.sv
module tlb_repl_ctrl_fsm
  import tlb_repl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regWrEn,
  input  logic             wrSvBit,
  input  logic             wrInvBit,
  input  logic             tlbAccess,
  input  logic             tlbLoad,
  input  logic [IDX_W-1:0] curCnt,
  input  logic [IDX_W-1:0] curBnd,
  input  logic             curSv,
  output ctrlStrobes_t     strb,
  output logic             invPulse,
  output logic             protoErr
);
  logic bndHit;
  assign bndHit = (curBnd != '0) && (curCnt == curBnd);

  always_comb begin
    strb.loadCfg = regWrEn;
    strb.stepCnt = !regWrEn && tlbAccess && !tlbLoad;
    strb.wrapCnt = strb.stepCnt && bndHit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      invPulse <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      invPulse <= regWrEn && wrInvBit;
      if (regWrEn && !wrInvBit && (wrSvBit != curSv)) protoErr <= 1'b1;
    end
  end

  // R11: a pulse always traces back to a triggering write one cycle earlier
  assert_inv_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    invPulse |-> $past(regWrEn && wrInvBit));
  // R12: the error flag never falls outside reset
  assert_perr_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    protoErr |=> protoErr);
endmodule

// File: rtl/tlb_repl_datapath.sv
module tlb_repl_datapath
  import tlb_repl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strb,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              tlbAccess,
  input  logic              tlbLoad,
  output logic [IDX_W-1:0]  curCnt,
  output logic [IDX_W-1:0]  curBnd,
  output logic              curSq,
  output logic              curSv,
  output logic [WORD_W-1:0] regRdData
);
  logic unusedWrBits;
  assign unusedWrBits = ^{regWrData[WORD_W-1:BND_LSB+IDX_W],
                          regWrData[CNT_LSB+IDX_W+1:CNT_LSB+IDX_W],
                          regWrData[SV_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curCnt <= '0;
      curBnd <= '0;
      curSq  <= 1'b0;
      curSv  <= 1'b0;
    end else if (strb.loadCfg) begin
      curCnt <= regWrData[CNT_LSB +: IDX_W];
      curBnd <= regWrData[BND_LSB +: IDX_W];
      curSq  <= regWrData[SQ_BIT];
      curSv  <= regWrData[SV_BIT];
    end else if (strb.wrapCnt) begin
      curCnt <= '0;
    end else if (strb.stepCnt) begin
      curCnt <= curCnt + 1'b1;
    end
  end

  always_comb begin
    regRdData = '0;
    regRdData[BND_LSB +: IDX_W] = curBnd;
    regRdData[CNT_LSB +: IDX_W] = curCnt;
    regRdData[SQ_BIT] = curSq;
    regRdData[SV_BIT] = curSv;
  end

  // R8: a write lands its counter field regardless of strobes
  assert_wr_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadCfg |=> curCnt == $past(regWrData[CNT_LSB +: IDX_W]));
  // R7: load strobe freezes the counter when no write is present
  assert_load_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbLoad && !strb.loadCfg) |=> $stable(curCnt));
  // R4: hitting a nonzero boundary on an access returns the counter to zero
  assert_bnd_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbAccess && !tlbLoad && !strb.loadCfg && curBnd != '0 && curCnt == curBnd)
      |=> curCnt == '0);
  // R5: with a zero boundary every access is a plain modulo-64 step
  assert_free_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tlbAccess && !tlbLoad && !strb.loadCfg && curBnd == '0)
      |=> curCnt == IDX_W'($past(curCnt) + 1'b1));
endmodule

// File: rtl/tlb_repl_ctrl.sv
module tlb_repl_ctrl
  import tlb_repl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        tlbAccess,
  input  logic        tlbLoad,
  input  logic        sqAccess,
  input  logic        sqUser,
  output logic [5:0]  replIndex,
  output logic        sqPrivOnly,
  output logic        singleVmMode,
  output logic        sqAddrErr,
  output logic        invPulse,
  output logic        protoErr
);
  ctrlStrobes_t     strb;
  logic [IDX_W-1:0] curCnt, curBnd;
  logic             curSq, curSv;

  tlb_repl_ctrl_fsm u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn),
    .wrSvBit(regWrData[SV_BIT]), .wrInvBit(regWrData[INV_BIT]),
    .tlbAccess(tlbAccess), .tlbLoad(tlbLoad),
    .curCnt(curCnt), .curBnd(curBnd), .curSv(curSv),
    .strb(strb), .invPulse(invPulse), .protoErr(protoErr)
  );

  tlb_repl_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .regWrData(regWrData),
    .tlbAccess(tlbAccess), .tlbLoad(tlbLoad),
    .curCnt(curCnt), .curBnd(curBnd), .curSq(curSq), .curSv(curSv),
    .regRdData(regRdData)
  );

  assign replIndex    = curCnt;
  assign sqPrivOnly   = curSq;
  assign singleVmMode = curSv;
  assign sqAddrErr    = sqAccess && sqUser && curSq;

  // R9: a privileged access never raises the address error
  assert_sq_priv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sqAccess && !sqUser) |-> !sqAddrErr);
endmodule

// File: tb/tb_tlb_repl_ctrl.sv
`timescale 1ns/1ps
module tb_tlb_repl_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        regWrEn = 0, tlbAccess = 0, tlbLoad = 0, sqAccess = 0, sqUser = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic [5:0]  replIndex;
  logic        sqPrivOnly, singleVmMode, sqAddrErr, invPulse, protoErr;

  tlb_repl_ctrl dut (.*);

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;
  logic [5:0] mCnt = 0, mBnd = 0;
  logic mSq = 0, mSv = 0, mInv = 0, mErr = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord();
    return {8'h0, mBnd, 2'b0, mCnt, mSq, mSv, 8'h0};
  endfunction

  function automatic logic [5:0] nextCnt(logic acc, logic ld);
    if (!acc || ld) return mCnt;
    if (mBnd != 0 && mCnt == mBnd) return 6'd0;
    return mCnt + 6'd1;
  endfunction

  task automatic checkAll();
    chk("R2 readback", regRdData, expWord());
    chk("R3-step index", {26'b0, replIndex}, {26'b0, mCnt});
    chk("R9 sq mode", {31'b0, sqPrivOnly}, {31'b0, mSq});
    chk("R10 vm mode", {31'b0, singleVmMode}, {31'b0, mSv});
    chk("R11 invalidate", {31'b0, invPulse}, {31'b0, mInv});
    chk("R12 proto err", {31'b0, protoErr}, {31'b0, mErr});
  endtask

  // drive at negedge, update model, check after the next edge
  task automatic step(logic wr, logic [31:0] d, logic acc, logic ld, logic sa, logic su);
    regWrEn = wr; regWrData = d; tlbAccess = acc; tlbLoad = ld;
    sqAccess = sa; sqUser = su;
    #1 chk("R9 addr err", {31'b0, sqAddrErr}, {31'b0, sa && su && mSq});
    if (wr) begin
      if (!d[2] && d[8] != mSv) mErr = 1;
      mInv = d[2];
      mCnt = d[15:10]; mBnd = d[23:18]; mSq = d[9]; mSv = d[8];
    end else begin
      mInv = 0;
      mCnt = nextCnt(acc, ld);
    end
    @(negedge clk);
    checkAll();
  endtask

  function automatic logic [31:0] cfg(logic [5:0] b, logic [5:0] c, logic sq, logic sv, logic inv);
    return {8'h0, b, 2'b0, c, sq, sv, 5'b0, inv, 2'b0};
  endfunction

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (2) @(negedge clk);
    rst_n = 1;
    checkAll(); // R1 reset state
    chk("R1 reset word", regRdData, 32'h0);
    // R3 plain increments
    repeat (3) step(0, 0, 1, 0, 0, 0);
    // R2 reserved bits ignore writes
    step(1, 32'hFFFF_FFFF & ~32'h0000_0104, 0, 0, 0, 0);
    chk("R2 reserved zero", regRdData & 32'hFC_0300_FF ^ 32'h0, 32'h0);
    // R4 wrap at boundary 5
    step(1, cfg(6'd5, 6'd4, 0, 0, 0), 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    chk("R4 wrap to zero", {26'b0, replIndex}, 32'd0);
    // R6 above boundary runs to 63 then wraps
    step(1, cfg(6'd5, 6'd62, 0, 0, 0), 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    chk("R6 reaches 63", {26'b0, replIndex}, 32'd63);
    step(0, 0, 1, 0, 0, 0);
    chk("R6 wraps after 63", {26'b0, replIndex}, 32'd0);
    // R5 zero boundary free run through 63
    step(1, cfg(6'd0, 6'd63, 0, 0, 0), 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0);
    chk("R5 63 to 0", {26'b0, replIndex}, 32'd0);
    // R7 load with access holds
    step(0, 0, 1, 1, 0, 0);
    chk("R7 load holds", {26'b0, replIndex}, 32'd0);
    // R8 write beats increment
    step(1, cfg(6'd0, 6'd17, 0, 0, 0), 1, 0, 0, 0);
    chk("R8 write priority", {26'b0, replIndex}, 32'd17);
    // R9 store-queue privilege
    step(1, cfg(6'd0, 6'd17, 1, 0, 0), 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 0);
    // R11 legal mode change with trigger, bit 2 reads 0
    step(1, cfg(6'd0, 6'd17, 1, 1, 1), 0, 0, 0, 0);
    chk("R11 pulse high", {31'b0, invPulse}, 32'd1);
    chk("R11 bit2 reads 0", {31'b0, regRdData[2]}, 32'd0);
    step(0, 0, 0, 0, 0, 0);
    chk("R11 pulse one cycle", {31'b0, invPulse}, 32'd0);
    chk("R12 legal change clean", {31'b0, protoErr}, 32'd0);
    // R10/R12 illegal change
    step(1, cfg(6'd0, 6'd17, 1, 0, 0), 0, 0, 0, 0);
    chk("R12 error set", {31'b0, protoErr}, 32'd1);
    chk("R10 back to multiple", {31'b0, singleVmMode}, 32'd0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic wr;
      r = $urandom;
      wr = ($urandom % 10) == 0;
      step(wr, r, $urandom % 4 != 0, $urandom % 5 == 0, $urandom % 2, $urandom % 2);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule